// File: doc/BRIEF.md
# Burst Window Register File

This block is the register front end of a small peripheral. A bus master reads and writes 16-bit registers placed on a 4-byte stride. One address, the burst window at byte offset 0x4C, has no storage of its own. Each access to it is steered to a backing register picked by a programmable base plus a hidden index. The hardware steps the index after every window access. A DMA engine can therefore move a run of consecutive registers while it keeps hitting one fixed address.

The steering setup register sits at byte offset 0x48. It holds a 5-bit base, counted in registers from offset 0x00, and a 5-bit burst length. A length of N gives N+1 transfers before the index goes back to zero. Backing registers occupy word slots 0 to 17, at byte offsets 0x00 to 0x44. A steered target outside that range reads as zero and drops the write. Read data is registered and shows up one cycle after the read strobe.

Top module: `burst_window_rf`

## Requirements
- R1: After reset, every backing register, the base, the length and the index are 0. A read of any register, the window included, returns 0x0000.
- R2: A write to byte offset 4*k, for k in 0..17, stores into backing register k. A read there returns that value on rdata in the cycle after rd_en is sampled. Address bits [1:0] are ignored.
- R3: The setup register at 0x48 holds the base in bits [4:0] and the length in bits [12:8]. All other bits read 0.
- R4: An access to 0x4C reaches backing register base+index. A read returns that register and a write stores into it.
- R5: The index advances by one after each window access. After the access made with index equal to the length, it returns to 0, so a length of N yields N+1 distinct targets per pass.
- R6: Any write to the setup register resets the index to 0.
- R7: When base+index is 18 or more, a window read returns 0 and a window write changes no register. The index still advances.
- R8: Reads and writes to any address other than 0x4C leave the index unchanged. The one exception is a write to the setup register, which resets it.
- R9: Addresses 0x50 to 0x7C read as 0, and writes there change nothing.
- R10: When wr_en and rd_en are both high, only the write is carried out and rdata keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 7 | Byte address of the access |
| wr_en | input | 1 | Write strobe, one access per cycle high |
| rd_en | input | 1 | Read strobe, one access per cycle high |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |

## Verification
The assertions assume that each cycle with a strobe high is exactly one access, and that strobes are clean after reset. A strobe held high over several cycles counts as several window accesses and advances the index each time. The stimulus drives strobes for a single cycle on the falling clock edge and samples rdata one full cycle later. Simultaneous read and write strobes are raised only in the dedicated R10 case. The sweep visits every base value against several lengths, so targets cross the top of the backing range.

// File: rtl/bw_pkg.sv
package bw_pkg;
    localparam int DATA_W  = 16;
    localparam int FIELD_W = 5;
    localparam int LEN_LSB = 8;

    typedef struct packed {
        logic [FIELD_W-1:0] base;
        logic [FIELD_W-1:0] len;
        logic [DATA_W-1:0]  rdata;
    } bw_state_t;
endpackage

// File: rtl/bw_index_ctr.sv
module bw_index_ctr #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] len,
    output logic [W-1:0] idx
);
    logic [W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (clr) begin
            idx_d = '0;
        end else if (step) begin
            idx_d = (idx_q == len) ? '0 : idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx = idx_q;
endmodule

// File: rtl/bw_redirect.sv
module bw_redirect #(
    parameter int W         = 5,
    parameter int NUM_PLAIN = 18
) (
    input  logic [W-1:0] base,
    input  logic [W-1:0] idx,
    output logic [W:0]   tgt,
    output logic         in_range
);
    always_comb begin
        tgt      = {1'b0, base} + {1'b0, idx};
        in_range = (tgt < (W+1)'(NUM_PLAIN));
    end
endmodule

// File: rtl/bw_store.sv
module bw_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 18,
    parameter int IDX_W  = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [IDX_W-1:0]              widx,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DEPTH-1:0][DATA_W-1:0]  rd_all
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_reg
        logic [DATA_W-1:0] reg_d, reg_q;

        always_comb begin
            reg_d = reg_q;
            if (we && (widx == IDX_W'(i))) reg_d = wdata;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) reg_q <= '0;
            else        reg_q <= reg_d;
        end

        assign rd_all[i] = reg_q;
    end
endmodule

// File: rtl/burst_window_rf.sv
module burst_window_rf
    import bw_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int CFG_WORD = 18,
    parameter int WIN_WORD = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata
);
    localparam int NUM_PLAIN = CFG_WORD;
    localparam int WORD_W    = ADDR_W - 2;
    localparam int IDX_W     = $clog2(NUM_PLAIN);

    bw_state_t st_d, st_q;

    logic [WORD_W-1:0]                  word;
    logic                               hit_plain, hit_cfg, hit_win;
    logic                               win_acc, cfg_wr;
    logic [FIELD_W-1:0]                 idx_q;
    logic [FIELD_W:0]                   tgt;
    logic                               tgt_ok;
    logic                               st_we;
    logic [IDX_W-1:0]                   st_widx;
    logic [NUM_PLAIN-1:0][DATA_W-1:0]   rd_all;
    logic [DATA_W-1:0]                  rd_val;

    assign word      = addr[ADDR_W-1:2];
    assign hit_plain = (word < WORD_W'(NUM_PLAIN));
    assign hit_cfg   = (word == WORD_W'(CFG_WORD));
    assign hit_win   = (word == WORD_W'(WIN_WORD));
    assign win_acc   = hit_win && (wr_en || rd_en);
    assign cfg_wr    = hit_cfg && wr_en;

    bw_index_ctr #(.W(FIELD_W)) idx_ctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cfg_wr),
        .step  (win_acc),
        .len   (st_q.len),
        .idx   (idx_q)
    );

    bw_redirect #(.W(FIELD_W), .NUM_PLAIN(NUM_PLAIN)) redir_i (
        .base     (st_q.base),
        .idx      (idx_q),
        .tgt      (tgt),
        .in_range (tgt_ok)
    );

    always_comb begin
        st_we   = wr_en && (hit_plain || (hit_win && tgt_ok));
        st_widx = hit_win ? tgt[IDX_W-1:0] : word[IDX_W-1:0];
    end

    bw_store #(.DATA_W(DATA_W), .DEPTH(NUM_PLAIN), .IDX_W(IDX_W)) store_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (st_we),
        .widx   (st_widx),
        .wdata  (wdata),
        .rd_all (rd_all)
    );

    always_comb begin
        rd_val = '0;
        if (hit_plain) begin
            rd_val = rd_all[word[IDX_W-1:0]];
        end else if (hit_cfg) begin
            rd_val[FIELD_W-1:0]               = st_q.base;
            rd_val[LEN_LSB +: FIELD_W]        = st_q.len;
        end else if (hit_win && tgt_ok) begin
            rd_val = rd_all[tgt[IDX_W-1:0]];
        end
    end

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.base = wdata[FIELD_W-1:0];
            st_d.len  = wdata[LEN_LSB +: FIELD_W];
        end
        if (rd_en && !wr_en) begin
            st_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;
endmodule

// File: rtl/bw_checker.sv
module bw_checker #(
    parameter int ADDR_W   = 7,
    parameter int CFG_WORD = 18,
    parameter int WIN_WORD = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [15:0]       rdata,
    input logic [4:0]        idx,
    input logic [4:0]        len
);
    logic [ADDR_W-3:0] w;
    assign w = addr[ADDR_W-1:2];

    // R5
    idx_within_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx <= len);

    // R6
    cfg_clears_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && w == (ADDR_W-2)'(CFG_WORD)) |=> (idx == 5'd0));

    // R8
    idx_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(w == (ADDR_W-2)'(WIN_WORD) && (wr_en || rd_en)) &&
         !(wr_en && w == (ADDR_W-2)'(CFG_WORD))) |=> $stable(idx));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && w > (ADDR_W-2)'(WIN_WORD)) |=> (rdata == 16'h0000));

    // R10
    both_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |=> $stable(rdata));
endmodule

bind burst_window_rf bw_checker #(
    .ADDR_W(ADDR_W), .CFG_WORD(CFG_WORD), .WIN_WORD(WIN_WORD)
) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (addr),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .rdata (rdata),
    .idx   (idx_q),
    .len   (st_q.len)
);

// File: tb/burst_window_rf_tb.sv
module burst_window_rf_tb_top;
    localparam int NP = 18;
    localparam logic [6:0] CFG_A = 7'h48;
    localparam logic [6:0] WIN_A = 7'h4C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    int total = 0, bad = 0;
    bit done = 1'b0;

    logic [15:0] model [NP];
    int m_base = 0, m_len = 0, m_idx = 0;

    always #2 clk = ~clk;

    burst_window_rf dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [6:0] a, logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [6:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic set_cfg(int b, int l);
        wr(CFG_A, 16'((l << 8) | b));
        m_base = b; m_len = l; m_idx = 0;
    endtask

    function automatic void step_idx();
        m_idx = (m_idx == m_len) ? 0 : m_idx + 1;
    endfunction

    initial begin
        logic [15:0] v;
        for (int i = 0; i < NP; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 rdata", rdata, 16'h0);
        rd(WIN_A, v); check("R1 window", v, 16'h0);
        rd(CFG_A, v); check("R1 cfg", v, 16'h0);
        rd(7'h20, v); check("R1 reg8", v, 16'h0);
        set_cfg(0, 0);

        // R2: direct writes and reads, low address bits ignored
        for (int k = 0; k < NP; k++) begin
            model[k] = 16'(16'hA500 + k * 16'h0111);
            wr(7'(k * 4 + (k % 4)), model[k]);
        end
        for (int k = 0; k < NP; k++) begin
            rd(7'(k * 4), v); check("R2 direct", v, model[k]);
        end

        // R3: field placement, extra bits dropped
        wr(CFG_A, 16'hFFFF);
        rd(CFG_A, v); check("R3 cfg fields", v, 16'h1F1F);
        set_cfg(3, 2);
        rd(CFG_A, v); check("R3 cfg value", v, 16'h0203);

        // R4 R5 R7: window read sweep over every base, several lengths
        foreach (model[k]) begin end
        for (int b = 0; b < 32; b++) begin
            for (int li = 0; li < 4; li++) begin
                int l;
                l = (li == 0) ? 0 : (li == 1) ? 1 : (li == 2) ? 3 : 7;
                set_cfg(b, l);
                for (int n = 0; n < l + 3; n++) begin
                    int t;
                    t = m_base + m_idx;
                    rd(WIN_A, v);
                    if (t < NP) check("R4 R5 window read", v, model[t]);
                    else        check("R7 out of range read", v, 16'h0);
                    step_idx();
                end
            end
        end

        // R8: direct accesses between window reads do not move the index
        set_cfg(4, 5);
        rd(WIN_A, v); check("R8 first", v, model[4]); step_idx();
        rd(7'h00, v); wr(7'h50, 16'h1234); rd(7'h44, v);
        rd(WIN_A, v); check("R8 held", v, model[5]); step_idx();

        // R6: cfg write mid-burst clears the index
        set_cfg(4, 5);
        rd(WIN_A, v); check("R6 restart", v, model[4]);

        // R4 R7: window writes, some past the top
        set_cfg(15, 4);
        for (int n = 0; n < 5; n++) begin
            int t;
            t = m_base + m_idx;
            wr(WIN_A, 16'(16'hC000 + n));
            if (t < NP) model[t] = 16'(16'hC000 + n);
            step_idx();
        end
        check("R7 index advanced", 16'(m_idx), 16'h0);
        for (int k = 0; k < NP; k++) begin
            rd(7'(k * 4), v); check("R4 R7 after window writes", v, model[k]);
        end

        // R9: unmapped region
        wr(7'h7C, 16'hBEEF);
        rd(7'h7C, v); check("R9 unmapped read", v, 16'h0);
        rd(7'h50, v); check("R9 unmapped read", v, 16'h0);

        // R10: both strobes high
        rd(7'h08, v);
        @(negedge clk);
        addr = 7'h0C; wdata = 16'h5A5A; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check("R10 rdata held", rdata, model[2]);
        model[3] = 16'h5A5A;
        rd(7'h0C, v); check("R10 write done", v, 16'h5A5A);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule